// File: doc/BRIEF.md
# Size-Aware Add/Subtract Condition-Flag Unit

This block performs integer add, subtract, compare, negate and the bitwise operations AND, OR, XOR and NOT on 32-bit operands. It works at one of three operand widths: byte, word or long. Both operands are sign-extended from the selected width before the operation. The result is sign-extended again from that width, and the condition flags are derived from the narrow view. There are five flags: extend X, negative N, zero Z, overflow V and carry C. They are held in a flag register that changes only when an operation is accepted with its flag-write enable set.

Operations enter through a valid/ready stream. A request transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle (`out_ready` high). The output stage holds the sign-extended result and a merged register image. While `out_valid` is high and `out_ready` is low, the output stage holds its values and refuses new requests. The merged image is the destination operand with only its low byte or word replaced, which is the value a data register takes when it is written back at a narrow width.

Top module: `szflag_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all five flags to 0 and drops `out_valid`. The flags are packed as `flags[4]`=X, `[3]`=N, `[2]`=Z, `[1]`=V, `[0]`=C.
- R2: `size` 0 selects byte (8 bits), 1 selects word (16 bits), and 2 or 3 select long (32 bits). `result` is the operation's value sign-extended from bit 7, 15 or 31. N is that sign bit, and Z is set exactly when the low byte, word or long is all zeros.
- R3: When `op`=0 (add), the result is dst+src. X and C are both set when the truncated sum is unsigned-less-than the truncated source. V is set when dst and src have equal sign bits at the selected size and the result's sign bit differs from them.
- R4: When `op`=1 (subtract), the result is dst−src. X and C are both set when the truncated dst is unsigned-less-than the truncated src. V is set when dst and src differ in sign at the selected size and the result's sign bit differs from dst's.
- R5: When `op`=2 (compare), N, Z, V and C are computed exactly as for subtract, X keeps its previous value, and `merged` equals dst unchanged.
- R6: When `op`=3 (negate), the result is 0−src. X and C are both set exactly when the truncated result is nonzero. V is set when both src and the result have their sign bits set at the selected size.
- R7: When `op` is 4 (AND), 5 (OR), 6 (XOR) or 7 (NOT of dst), N and Z are set from the size-extended result, V and C are cleared, and X is kept.
- R8: For every operation other than compare, `merged` takes the low 8 or 16 bits of the result for byte or word sizes and keeps dst's upper bits. For long size, `merged` is the whole result.
- R9: The flags update on the rising edge that accepts a request with `flag_we` high. They hold their value when a request is accepted with `flag_we` low and when no request is accepted.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `result`, `merged` and `out_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| op | input | 3 | Operation select (see R3 to R7) |
| size | input | 2 | Operand width select (see R2) |
| flag_we | input | 1 | Flag register write enable for this request |
| dst_opnd | input | 32 | Destination operand and register image for the merge |
| src_opnd | input | 32 | Source operand |
| out_valid | output | 1 | Output stage holds a result |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 32 | Result, sign-extended from the selected size |
| merged | output | 32 | Destination image with the narrow result merged in |
| flags | output | 5 | Registered flags {X,N,Z,V,C} |

## Verification
Assertions check on every cycle that compare leaves X alone and that add, subtract and negate leave C equal to X. They also check that logic operations clear V and C, that a negate's carry matches a nonzero result, that the flags hold without an accepted write, and that the output stage is stable under back-pressure. The numeric values of the flags and results at each width can only be shown by the bench's scenarios: the byte and word overflow and carry boundaries, negation of the most negative value, the partial-register merge, and handshake stalls. In those scenarios the bench compares the design against a model of its own.

// File: rtl/szf_pkg.sv
package szf_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned SIZE_W = 2;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_NEG = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_NOT = 3'd7
  } alu_op_e;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LALT = 2'd3
  } op_size_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  function automatic logic is_logic_op(input logic [OP_W-1:0] o);
    return o[2];
  endfunction
endpackage

// File: rtl/szf_sizer.sv
module szf_sizer
  import szf_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned WW = WORD_W
) (
  input  logic [W-1:0]      din,
  input  logic [SIZE_W-1:0] size,
  output logic [W-1:0]      ext,
  output logic [W-1:0]      trunc,
  output logic              sgn
);
  localparam logic [W-1:0] MASK_B = {{(W-BW){1'b0}}, {BW{1'b1}}};
  localparam logic [W-1:0] MASK_W = {{(W-WW){1'b0}}, {WW{1'b1}}};
  localparam logic [W-1:0] MASK_L = {W{1'b1}};

  logic [W-1:0] mask;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin mask = MASK_B; sgn = din[BW-1]; end
      SZ_WORD: begin mask = MASK_W; sgn = din[WW-1]; end
      default: begin mask = MASK_L; sgn = din[W-1];  end
    endcase
    trunc = din & mask;
    ext   = sgn ? (trunc | ~mask) : trunc;
  end
endmodule

// File: rtl/szf_arith.sv
module szf_arith
  import szf_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op,
  input  logic [SIZE_W-1:0] size,
  input  logic [W-1:0]      dst,
  input  logic [W-1:0]      src,
  output logic [W-1:0]      raw,
  output logic [W-1:0]      res_ext,
  output logic              f_n,
  output logic              f_z,
  output logic              f_v,
  output logic              f_c
);
  logic [W-1:0] d_ext, d_tr, s_ext, s_tr, r_tr;
  logic         d_sg, s_sg, r_sg;

  szf_sizer #(.W(W)) u_dsz (.din(dst), .size(size), .ext(d_ext), .trunc(d_tr), .sgn(d_sg));
  szf_sizer #(.W(W)) u_ssz (.din(src), .size(size), .ext(s_ext), .trunc(s_tr), .sgn(s_sg));

  always_comb begin
    unique case (op)
      OP_ADD:  raw = d_ext + s_ext;
      OP_NEG:  raw = '0 - s_ext;
      default: raw = d_ext - s_ext;
    endcase
  end

  szf_sizer #(.W(W)) u_rsz (.din(raw), .size(size), .ext(res_ext), .trunc(r_tr), .sgn(r_sg));

  always_comb begin
    f_n = r_sg;
    f_z = (r_tr == '0);
    unique case (op)
      OP_ADD: begin
        f_c = (r_tr < s_tr);
        f_v = (d_sg == s_sg) && (r_sg != d_sg);
      end
      OP_NEG: begin
        f_c = (r_tr != '0);
        f_v = s_sg && r_sg;
      end
      default: begin
        f_c = (d_tr < s_tr);
        f_v = (d_sg != s_sg) && (r_sg != d_sg);
      end
    endcase
  end

  AST_NEG_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NEG) |-> (f_c == (res_ext != '0))); // R6
  AST_NEG_SRC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NEG && s_tr == '0) |-> (f_z && !f_v)); // R6
endmodule

// File: rtl/szf_logic.sv
module szf_logic
  import szf_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [OP_W-1:0]   op,
  input  logic [SIZE_W-1:0] size,
  input  logic [W-1:0]      dst,
  input  logic [W-1:0]      src,
  output logic [W-1:0]      raw,
  output logic [W-1:0]      res_ext,
  output logic              f_n,
  output logic              f_z
);
  logic [W-1:0] r_tr;

  always_comb begin
    unique case (op[1:0])
      2'd0:    raw = dst & src;
      2'd1:    raw = dst | src;
      2'd2:    raw = dst ^ src;
      default: raw = ~dst;
    endcase
  end

  szf_sizer #(.W(W)) u_lsz (.din(raw), .size(size), .ext(res_ext), .trunc(r_tr), .sgn(f_n));

  assign f_z = (r_tr == '0);
endmodule

// File: rtl/szf_ccr.sv
module szf_ccr
  import szf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic keep_x,
  input  logic c_to_x,
  input  logic clr_vc,
  input  ccr_t nxt,
  output ccr_t ccr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ccr <= '0;
    end else if (upd) begin
      ccr.n <= nxt.n;
      ccr.z <= nxt.z;
      ccr.v <= nxt.v;
      ccr.c <= nxt.c;
      if (!keep_x) ccr.x <= nxt.x;
    end
  end

  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(ccr)); // R9
  AST_CMP_KEEPS_X: assert property (@(posedge clk) disable iff (rst)
    (upd && keep_x) |=> (ccr.x == $past(ccr.x))); // R5
  AST_X_EQ_C: assert property (@(posedge clk) disable iff (rst)
    (upd && c_to_x) |=> (ccr.x == ccr.c)); // R3
  AST_LOGIC_CLR: assert property (@(posedge clk) disable iff (rst)
    (upd && clr_vc) |=> (!ccr.v && !ccr.c)); // R7
endmodule

// File: rtl/szflag_alu.sv
module szflag_alu
  import szf_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OP_W-1:0]     op,
  input  logic [SIZE_W-1:0]   size,
  input  logic                flag_we,
  input  logic [DATA_W-1:0]   dst_opnd,
  input  logic [DATA_W-1:0]   src_opnd,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   result,
  output logic [DATA_W-1:0]   merged,
  output logic [4:0]          flags
);
  localparam logic [DATA_W-1:0] KEEP_B = {{(DATA_W-BYTE_W){1'b1}}, {BYTE_W{1'b0}}};
  localparam logic [DATA_W-1:0] KEEP_W = {{(DATA_W-WORD_W){1'b1}}, {WORD_W{1'b0}}};

  logic [DATA_W-1:0] a_raw, a_ext, l_raw, l_ext, sel_raw, sel_ext, keep_mask, mrg_nxt;
  logic              a_n, a_z, a_v, a_c, l_n, l_z;
  logic              accept, lg, is_cmp;
  ccr_t              nxt, ccr;

  szf_arith #(.W(DATA_W)) u_arith (
    .clk(clk), .rst(rst), .op(op), .size(size), .dst(dst_opnd), .src(src_opnd),
    .raw(a_raw), .res_ext(a_ext), .f_n(a_n), .f_z(a_z), .f_v(a_v), .f_c(a_c)
  );

  szf_logic #(.W(DATA_W)) u_logic (
    .op(op), .size(size), .dst(dst_opnd), .src(src_opnd),
    .raw(l_raw), .res_ext(l_ext), .f_n(l_n), .f_z(l_z)
  );

  assign lg     = is_logic_op(op);
  assign is_cmp = (op == OP_CMP);
  assign accept = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;

  always_comb begin
    if (lg) begin
      sel_raw = l_raw;
      sel_ext = l_ext;
      nxt     = '{x: 1'b0, n: l_n, z: l_z, v: 1'b0, c: 1'b0};
    end else begin
      sel_raw = a_raw;
      sel_ext = a_ext;
      nxt     = '{x: a_c, n: a_n, z: a_z, v: a_v, c: a_c};
    end
    unique case (size)
      SZ_BYTE: keep_mask = KEEP_B;
      SZ_WORD: keep_mask = KEEP_W;
      default: keep_mask = '0;
    endcase
    if (is_cmp) mrg_nxt = dst_opnd;
    else        mrg_nxt = (dst_opnd & keep_mask) | (sel_raw & ~keep_mask);
  end

  szf_ccr u_ccr (
    .clk(clk), .rst(rst), .upd(accept && flag_we), .keep_x(lg || is_cmp),
    .c_to_x(!lg && !is_cmp), .clr_vc(lg), .nxt(nxt), .ccr(ccr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      merged    <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      result    <= sel_ext;
      merged    <= mrg_nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign flags = ccr;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(merged))); // R10
  AST_NO_ACCEPT_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R10
  AST_CMP_MERGE: assert property (@(posedge clk) disable iff (rst)
    (accept && is_cmp) |=> (merged == $past(dst_opnd))); // R5
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid); // R10
endmodule

// File: tb/szflag_alu_bench.sv
module szflag_alu_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst, in_valid, in_ready, flag_we, out_valid, out_ready;
  logic [2:0]  op;
  logic [1:0]  size;
  logic [31:0] dst_opnd, src_opnd, result, merged;
  logic [4:0]  flags;

  int n_chk = 0, n_bad = 0;
  logic [4:0] mflags;

  szflag_alu u_szflag_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .op(op), .size(size),
    .flag_we(flag_we), .dst_opnd(dst_opnd), .src_opnd(src_opnd), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .merged(merged), .flags(flags)
  );

  always #(CLK_P/2) clk = ~clk;

  // Model: returns {flags, result, merged}
  function automatic logic [68:0] model(input logic [2:0] o, input logic [1:0] sz,
                                        input logic [31:0] d, input logic [31:0] s,
                                        input logic [4:0] of);
    logic [31:0] m, de, se, r, rt, re, dt, st, mg;
    int nb;
    logic x, n, z, v, c, ds, ss, rs;
    nb = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m  = (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
    dt = d & m; st = s & m;
    ds = dt[nb-1]; ss = st[nb-1];
    de = ds ? (dt | ~m) : dt;
    se = ss ? (st | ~m) : st;
    case (o)
      3'd0: r = de + se;
      3'd3: r = 32'd0 - se;
      3'd4: r = d & s;
      3'd5: r = d | s;
      3'd6: r = d ^ s;
      3'd7: r = ~d;
      default: r = de - se;
    endcase
    rt = r & m; rs = rt[nb-1];
    re = rs ? (rt | ~m) : rt;
    n = rs; z = (rt == 32'd0);
    x = of[4]; v = 1'b0; c = 1'b0;
    case (o)
      3'd0: begin c = rt < st; x = c; v = (ds == ss) && (rs != ds); end
      3'd1: begin c = dt < st; x = c; v = (ds != ss) && (rs != ds); end
      3'd2: begin c = dt < st;        v = (ds != ss) && (rs != ds); end
      3'd3: begin c = rt != 0; x = c; v = ss && rs; end
      default: ;
    endcase
    mg = (o == 3'd2) ? d : ((d & ~m) | (r & m));
    return {x, n, z, v, c, re, mg};
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [1:0] sz, input logic [31:0] d,
                        input logic [31:0] s, input logic we);
    logic [68:0] e;
    @(negedge clk);
    op = o; size = sz; dst_opnd = d; src_opnd = s; flag_we = we; in_valid = 1'b1;
    e = model(o, sz, d, s, mflags);
    @(negedge clk);
    in_valid = 1'b0;
    if (we) mflags = e[68:64];
    chk({tag(o), " result R2"}, result, e[63:32]);
    chk({tag(o), " merged R8"}, merged, e[31:0]);
    chk({tag(o), " flags R9"}, {27'd0, flags}, {27'd0, mflags});
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [68:0] ea, eb;
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; flag_we = 1'b0;
    op = '0; size = '0; dst_opnd = '0; src_opnd = '0; mflags = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 flags", {27'd0, flags}, 32'd0);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);

    run_op(3'd0, 2'd0, 32'hAAAA_AA7F, 32'h0000_0001, 1'b1); // R3 byte overflow
    run_op(3'd0, 2'd0, 32'h1234_56FF, 32'h0000_0001, 1'b1); // R3 byte carry, zero
    run_op(3'd2, 2'd1, 32'h0000_0005, 32'h0000_0003, 1'b1); // R5 keeps X set
    run_op(3'd1, 2'd1, 32'hFFFF_0000, 32'h0000_0001, 1'b1); // R4 word borrow
    run_op(3'd1, 2'd2, 32'h8000_0000, 32'h0000_0001, 1'b1); // R4 long overflow
    run_op(3'd3, 2'd0, 32'h0000_0080, 32'h0000_0080, 1'b1); // R6 most negative byte
    run_op(3'd3, 2'd1, 32'h5555_5555, 32'hABCD_0000, 1'b1); // R6 zero result
    run_op(3'd0, 2'd1, 32'h0000_FFFF, 32'h0000_0001, 1'b1); // R3 sets X
    run_op(3'd4, 2'd0, 32'hFFFF_FF80, 32'h0000_00F0, 1'b1); // R7 X kept
    run_op(3'd7, 2'd1, 32'h1234_FFFF, 32'h0, 1'b1);         // R7 not -> zero
    run_op(3'd5, 2'd3, 32'h8000_0000, 32'h0000_0001, 1'b1); // R2 size 3 = long
    run_op(3'd0, 2'd0, 32'h0000_0010, 32'h0000_00F0, 1'b0); // R9 hold
    run_op(3'd1, 2'd1, 32'hDEAD_0002, 32'h0000_0001, 1'b1); // R8 merge word

    // R10 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    op = 3'd0; size = 2'd2; dst_opnd = 32'h7FFF_FFFF; src_opnd = 32'd1; flag_we = 1'b1;
    in_valid = 1'b1;
    ea = model(3'd0, 2'd2, 32'h7FFF_FFFF, 32'd1, mflags);
    @(negedge clk);
    mflags = ea[68:64];
    op = 3'd1; size = 2'd0; dst_opnd = 32'h0000_0001; src_opnd = 32'h0000_0002;
    eb = model(3'd1, 2'd0, 32'h1, 32'h2, mflags);
    chk("R10 in_ready low", {31'd0, in_ready}, 32'd0);
    chk("R10 first result", result, ea[63:32]);
    @(negedge clk);
    chk("R10 result held", result, ea[63:32]);
    chk("R10 flags held R9", {27'd0, flags}, {27'd0, mflags});
    chk("R10 out_valid held", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    mflags = eb[68:64];
    chk("R10 second result", result, eb[63:32]);
    chk("R10 second flags", {27'd0, flags}, {27'd0, mflags});

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if ((i % 5) == 0) b = a;
      if ((i % 7) == 0) a = a & 32'hFFFF_FF80;
      run_op(3'($urandom % 8), 2'($urandom % 4), a, b, ($urandom % 4) != 0);
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 flags after reset", {27'd0, flags}, 32'd0);
    chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule